// File: doc/BRIEF.md
# External Bus Hold and Backoff Arbiter

This block decides who owns the external bus at any moment: the local bus master or an outside agent. An outside agent can ask for the bus in two ways. A polite hold request is granted only when no access is in flight, and the grant is then kept for as long as the request stays high. A backoff request takes effect at once. It suspends the access in flight, floats the bus, and once released it makes the master issue its address strobe again so that the interrupted access restarts.

The arbiter watches two flags from the master: a request is pending, and an access is in progress. It drives a hold acknowledge, a bus-request indication for external arbitration logic, a float enable for every bus output driver, a suspend signal to the master, and a one-cycle resume pulse that makes the master re-issue the suspended access. The hold acknowledge does not depend on reset, so an outside agent can take the bus while the local side is still in reset.

Top module: `bus_hold_arbiter`

## Requirements
- R1: The hold grant is decided at each rising clock edge. With `holdReq` high, `holdAck` rises one clock later only if `accessActive` was low at that edge, or reset was active. While an access is in progress, `holdAck` stays low.
- R2: Whenever `holdAck` is high, `floatEn` is high.
- R3: Out of reset, a high `backoffReq` drives `suspend` and `floatEn` high in the same cycle, with no clock delay.
- R4: If `backoffReq` is high at an edge where `accessActive` is high and `holdAck` is low, the access is recorded as suspended. At the first later edge where `backoffReq` is low, `resume` goes high for exactly one cycle and the suspension is cleared.
- R5: `busReq` is high whenever `reqPending` is high or a suspended access is outstanding. This holds whatever the value of `holdAck`.
- R6: During reset (`rstN` low), a high `holdReq` is granted one clock later. The grant is kept across the release of reset for as long as `holdReq` stays high.
- R7: `holdAck` falls one clock after `holdReq` is sampled low.
- R8: If `holdReq` and `backoffReq` are both high in a cycle where an access is in progress, the backoff wins: `suspend` goes high and `holdAck` stays low.
- R9: Reset clears any recorded suspension, forces `resume` low and holds `suspend` low.
- R10: A backoff while no access is in progress floats the bus but gives no `resume` pulse when it is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| holdReq | input | 1 | Outside agent asks for the bus at a request boundary |
| backoffReq | input | 1 | Outside agent forces the master off the bus at once |
| reqPending | input | 1 | Master has a bus request waiting |
| accessActive | input | 1 | Master has an access in flight |
| holdAck | output | 1 | Bus handed to the outside agent |
| busReq | output | 1 | Local side wants the bus |
| floatEn | output | 1 | Tri-state all address, data and control outputs |
| suspend | output | 1 | Master must stall its current access |
| resume | output | 1 | One-cycle pulse: master re-issues its address strobe |

## Verification
The bench raises hold in the middle of an access. A design that grants early would show `holdAck` before `accessActive` falls. The bench also raises hold and backoff together, where a wrong priority would grant the hold in place of suspending. It runs a backoff with no access in flight, where a careless design would emit a spurious `resume`. It drops `reqPending` while an access is suspended, to catch a `busReq` that forgets the suspended access. Finally, it applies hold during reset and backoff across a reset, to expose an acknowledge cleared by reset or a suspension that survives it.

// File: rtl/bus_hold_arbiter_pkg.sv
package bus_hold_arbiter_pkg;
  typedef struct packed {
    logic holdNext;
    logic suspSet;
    logic resumeFire;
  } arbStrobe_t;
endpackage

// File: rtl/bus_hold_arbiter_ctrl.sv
module bus_hold_arbiter_ctrl
  import bus_hold_arbiter_pkg::*;
(
  input  logic       rstN,
  input  logic       holdReq,
  input  logic       backoffReq,
  input  logic       accessActive,
  input  logic       holdAckQ,
  input  logic       suspPendQ,
  output arbStrobe_t strb,
  output logic       suspend
);
  logic inReset;
  logic atBoundary;

  always_comb begin
    inReset    = !rstN;
    // a boundary: no access in flight, or the grant is already held
    atBoundary = inReset || holdAckQ || !accessActive;
    strb.holdNext   = holdReq && atBoundary;
    // backoff takes the bus from a live access; it outranks hold
    strb.suspSet    = !inReset && backoffReq && accessActive && !holdAckQ;
    strb.resumeFire = !inReset && suspPendQ && !backoffReq;
    suspend         = !inReset && backoffReq;
  end
endmodule

// File: rtl/bus_hold_arbiter_state.sv
module bus_hold_arbiter_state
  import bus_hold_arbiter_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  arbStrobe_t strb,
  input  logic       reqPending,
  input  logic       suspend,
  output logic       holdAckQ,
  output logic       suspPendQ,
  output logic       resume,
  output logic       busReq,
  output logic       floatEn
);
  // grant register deliberately not reset: hold works during reset
  always_ff @(posedge clk) begin
    holdAckQ <= strb.holdNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      suspPendQ <= 1'b0;
      resume    <= 1'b0;
    end else begin
      resume <= strb.resumeFire;
      if (strb.suspSet)
        suspPendQ <= 1'b1;
      else if (strb.resumeFire)
        suspPendQ <= 1'b0;
    end
  end

  always_comb begin
    busReq  = reqPending || suspPendQ;
    floatEn = holdAckQ || suspend;
  end
endmodule

// File: rtl/bus_hold_arbiter.sv
module bus_hold_arbiter
  import bus_hold_arbiter_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic holdReq,
  input  logic backoffReq,
  input  logic reqPending,
  input  logic accessActive,
  output logic holdAck,
  output logic busReq,
  output logic floatEn,
  output logic suspend,
  output logic resume
);
  arbStrobe_t strb;
  logic       holdAckQ;
  logic       suspPendQ;

  bus_hold_arbiter_ctrl u_ctrl (
    .rstN        (rstN),
    .holdReq     (holdReq),
    .backoffReq  (backoffReq),
    .accessActive(accessActive),
    .holdAckQ    (holdAckQ),
    .suspPendQ   (suspPendQ),
    .strb        (strb),
    .suspend     (suspend)
  );

  bus_hold_arbiter_state u_state (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .reqPending(reqPending),
    .suspend   (suspend),
    .holdAckQ  (holdAckQ),
    .suspPendQ (suspPendQ),
    .resume    (resume),
    .busReq    (busReq),
    .floatEn   (floatEn)
  );

  assign holdAck = holdAckQ;
endmodule

// File: rtl/bus_hold_arbiter_chk.sv
module bus_hold_arbiter_chk (
  input logic clk,
  input logic rstN,
  input logic holdReq,
  input logic backoffReq,
  input logic reqPending,
  input logic accessActive,
  input logic holdAck,
  input logic busReq,
  input logic floatEn,
  input logic suspend,
  input logic resume
);
  // R1
  no_midaccess_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accessActive && !holdAck) |=> !holdAck);
  // R2
  float_when_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    holdAck |-> floatEn);
  // R3
  backoff_floats_chk: assert property (@(posedge clk) disable iff (!rstN)
    backoffReq |-> (suspend && floatEn));
  // R4
  resume_after_backoff_chk: assert property (@(posedge clk) disable iff (!rstN)
    (backoffReq && accessActive && !holdAck) ##1 (!backoffReq && rstN) |=> resume);
  // R4
  resume_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    resume |=> !resume);
  // R5
  busreq_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqPending |-> busReq);
  // R7
  release_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !holdReq |=> !holdAck);
  // R8
  backoff_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (holdReq && backoffReq && accessActive && !holdAck) |=> !holdAck);
endmodule

bind bus_hold_arbiter bus_hold_arbiter_chk u_chk (
  .clk(clk), .rstN(rstN), .holdReq(holdReq), .backoffReq(backoffReq),
  .reqPending(reqPending), .accessActive(accessActive), .holdAck(holdAck),
  .busReq(busReq), .floatEn(floatEn), .suspend(suspend), .resume(resume)
);

// File: tb/bus_hold_arbiter_tb.sv
module bus_hold_arbiter_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic holdReq = 1'b0;
  logic backoffReq = 1'b0;
  logic reqPending = 1'b0;
  logic accessActive = 1'b0;
  logic holdAck, busReq, floatEn, suspend, resume;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  typedef struct {
    logic [4:0] exp;   // {holdAck, busReq, floatEn, suspend, resume}
    string      tag;
  } expItem_t;
  expItem_t sbq[$];

  always #2 clk = ~clk;  // 250 MHz

  bus_hold_arbiter u_dut (
    .clk(clk), .rstN(rstN), .holdReq(holdReq), .backoffReq(backoffReq),
    .reqPending(reqPending), .accessActive(accessActive), .holdAck(holdAck),
    .busReq(busReq), .floatEn(floatEn), .suspend(suspend), .resume(resume)
  );

  // driver: inputs applied at the falling edge, expectation for after the next rising edge
  task automatic step(input logic rN, input logic h, input logic b,
                      input logic r, input logic a, input logic [4:0] e,
                      input string tag);
    expItem_t it;
    @(negedge clk);
    rstN = rN; holdReq = h; backoffReq = b; reqPending = r; accessActive = a;
    it.exp = e;
    it.tag = tag;
    sbq.push_back(it);
  endtask

  // monitor: compare just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sbq.size() > 0) begin
        expItem_t it;
        logic [4:0] act;
        it  = sbq.pop_front();
        act = {holdAck, busReq, floatEn, suspend, resume};
        nChecks++;
        if (act !== it.exp) begin
          nFails++;
          $display("FAIL %s: {ha,br,fl,su,re} actual %b expected %b", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired before all R checks ran");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    //   rN h  b  r  a   ha br fl su re
    step(0, 0, 0, 0, 0, 5'b00000, "R9 reset state");
    step(0, 1, 0, 0, 0, 5'b10100, "R6 hold granted in reset");
    step(1, 1, 0, 0, 0, 5'b10100, "R6 grant kept past reset");
    step(1, 1, 0, 1, 0, 5'b11100, "R5 busReq while held, R2 float");
    step(1, 0, 0, 1, 0, 5'b01000, "R7 release after one clock");
    step(1, 0, 0, 1, 1, 5'b01000, "R1 access starts");
    step(1, 1, 0, 1, 1, 5'b01000, "R1 no grant mid-access");
    step(1, 1, 0, 0, 1, 5'b00000, "R1 still no grant mid-access");
    step(1, 1, 0, 0, 0, 5'b10100, "R1 grant after completion, R2");
    step(1, 0, 0, 0, 0, 5'b00000, "R7 release");
    step(1, 0, 0, 1, 1, 5'b01000, "R5 new access");
    step(1, 0, 1, 1, 1, 5'b01110, "R3 backoff suspends at once");
    step(1, 0, 1, 0, 1, 5'b01110, "R5 busReq from suspended access");
    step(1, 0, 0, 0, 1, 5'b00001, "R4 resume pulse");
    step(1, 0, 0, 0, 1, 5'b00000, "R4 resume lasts one cycle");
    step(1, 1, 1, 1, 1, 5'b01110, "R8 backoff beats hold");
    step(1, 1, 0, 1, 1, 5'b01001, "R8 no grant, R4 resume");
    step(1, 1, 0, 0, 0, 5'b10100, "R1 grant once idle");
    step(1, 0, 0, 0, 0, 5'b00000, "R7 release");
    step(1, 0, 1, 0, 0, 5'b00110, "R10 idle backoff floats");
    step(1, 0, 0, 0, 0, 5'b00000, "R10 no resume after idle backoff");
    step(1, 0, 1, 1, 1, 5'b01110, "R3 backoff before reset");
    step(0, 0, 1, 1, 1, 5'b01000, "R9 reset clears suspension");
    step(1, 0, 0, 0, 0, 5'b00000, "R9 no resume after reset");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule